// File: doc/BRIEF.md
# Incoming Uncorrectable Error Fill Router

This block sits where read data comes back from the system bus after its ECC check. Each returned line carries an error status: clean, raw uncorrectable, or marked uncorrectable. It also carries a cacheable flag and the kind of request that asked for it (instruction fetch, load, store or doubleword store). The block does not raise an error when the data arrives. For cacheable lines it writes the unified level-2 cache and one level-1 cache in the same cycle. Bad data is carried as poisoned cache contents: the level-2 and level-1 data copies get a marked-uncorrectable attribute, and the level-1 instruction copy gets a parity bit that is deliberately wrong.

For every request slot the block keeps a one-bit poison flag and the request kind. When the consuming instruction later signals execution on the same slot, the block raises either an instruction-access error or a data-access error, both of the marked-uncorrectable class. It then clears the flag, so the error is reported only once. A doubleword store never raises the error.

Top module: `ue_fill_router`

## Requirements
- R1: A cacheable response with clean status (rsp_err = 0) produces fill_valid one cycle later, with fill_data equal to rsp_data and l2_fill_mark = 0. The level-1 target is l1i_fill_en for kind 0 (fetch) and l1d_fill_en for kinds 1, 2 and 3 (load, store, doubleword store). l1d_fill_mark = 0, and l1i_fill_par is the even parity (XOR of all bits) of the data.
- R2: A cacheable response with rsp_err of 1 (raw) or 2 (marked) is written to level 2 with l2_fill_mark = 1. A raw status is never written unmarked.
- R3: A cacheable fetch with an uncorrectable status fills level 1 through l1i_fill_en, and l1i_fill_par is the inverse of the data's even parity. l1d_fill_en stays 0.
- R4: A cacheable load, store or doubleword store with an uncorrectable status fills level 1 through l1d_fill_en with l1d_fill_mark = 1. l1i_fill_en stays 0.
- R5: A noncacheable response produces no fill write: fill_valid, l1i_fill_en and l1d_fill_en all stay 0.
- R6: No error output is raised in the cycle after a response, whatever its status.
- R7: An execute strobe on a slot whose last response was a noncacheable fetch with an uncorrectable status raises err_inst for one cycle, one cycle after the strobe.
- R8: An execute strobe on a slot whose last response was a noncacheable load or store with an uncorrectable status raises err_data one cycle after the strobe.
- R9: An execute strobe on a slot holding a poisoned cacheable line raises err_inst for a fetch and err_data for a load or store.
- R10: An execute strobe on a slot whose request was a doubleword store raises no error.
- R11: An execute strobe on a slot whose last response was clean, or on a slot that was never filled since reset, raises no error.
- R12: The poison flag of a slot clears on its execute strobe. A second strobe on the same slot with no new response in between raises no error.
- R13: err_inst and err_data are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_valid | input | 1 | Returned line is present |
| rsp_slot | input | SW | Request slot of the returned line |
| rsp_data | input | DW | Returned data |
| rsp_err | input | 2 | Status: 0 clean, 1 raw uncorrectable, 2 or 3 marked uncorrectable |
| rsp_cacheable | input | 1 | Line may be cached |
| rsp_kind | input | 2 | Request kind: 0 fetch, 1 load, 2 store, 3 doubleword store |
| ex_valid | input | 1 | Consuming instruction executes |
| ex_slot | input | SW | Slot consumed by the executing instruction |
| fill_valid | output | 1 | Single fill pulse for level 2 and level 1 |
| fill_data | output | DW | Fill data |
| l2_fill_mark | output | 1 | Level-2 fill is marked uncorrectable |
| l1i_fill_en | output | 1 | Level-1 instruction cache fill |
| l1i_fill_par | output | 1 | Parity bit written with the instruction fill |
| l1d_fill_en | output | 1 | Level-1 data cache fill |
| l1d_fill_mark | output | 1 | Level-1 data fill is marked uncorrectable |
| err_inst | output | 1 | Instruction-access error, marked-uncorrectable class |
| err_data | output | 1 | Data-access error, marked-uncorrectable class |

## Verification
Every result is registered once. The fill outputs are due in the cycle after the response cycle, and the error outputs in the cycle after the execute strobe. The bench drives each stimulus for exactly one cycle on a falling edge and samples on the next falling edge, which falls in that one-cycle window. At the fill sample it also checks that both error outputs are low, which shows that nothing is raised on arrival. Responses and strobes are never applied in the same cycle, so a slot's poison state is unambiguous when the bench model predicts the strobe result.

// File: rtl/ue_fill_router.sv
module ue_fill_router #(
  parameter int DW    = 64,
  parameter int SLOTS = 8,
  localparam int SW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rsp_valid,
  input  logic [SW-1:0] rsp_slot,
  input  logic [DW-1:0] rsp_data,
  input  logic [1:0]    rsp_err,
  input  logic          rsp_cacheable,
  input  logic [1:0]    rsp_kind,
  input  logic          ex_valid,
  input  logic [SW-1:0] ex_slot,
  output logic          fill_valid,
  output logic [DW-1:0] fill_data,
  output logic          l2_fill_mark,
  output logic          l1i_fill_en,
  output logic          l1i_fill_par,
  output logic          l1d_fill_en,
  output logic          l1d_fill_mark,
  output logic          err_inst,
  output logic          err_data
);
  localparam logic [1:0] K_FETCH = 2'd0;
  localparam logic [1:0] K_DWST  = 2'd3;

  logic             ue, fill, is_fetch;
  logic [SLOTS-1:0] poison;
  logic [1:0]       pkind [SLOTS];
  logic             hit;
  logic [1:0]       hkind;

  assign ue       = rsp_err != 2'd0;
  assign fill     = rsp_valid && rsp_cacheable;
  assign is_fetch = rsp_kind == K_FETCH;
  assign hit      = ex_valid && poison[ex_slot];
  assign hkind    = pkind[ex_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_valid    <= 1'b0;
      fill_data     <= '0;
      l2_fill_mark  <= 1'b0;
      l1i_fill_en   <= 1'b0;
      l1i_fill_par  <= 1'b0;
      l1d_fill_en   <= 1'b0;
      l1d_fill_mark <= 1'b0;
    end else begin
      fill_valid    <= fill;
      fill_data     <= rsp_data;
      l2_fill_mark  <= fill && ue;
      l1i_fill_en   <= fill && is_fetch;
      l1i_fill_par  <= (^rsp_data) ^ (ue && is_fetch);
      l1d_fill_en   <= fill && !is_fetch;
      l1d_fill_mark <= fill && !is_fetch && ue;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      poison   <= '0;
      err_inst <= 1'b0;
      err_data <= 1'b0;
      for (int i = 0; i < SLOTS; i++) pkind[i] <= K_FETCH;
    end else begin
      err_inst <= hit && hkind == K_FETCH;
      err_data <= hit && hkind != K_FETCH && hkind != K_DWST;
      if (ex_valid) poison[ex_slot] <= 1'b0;
      if (rsp_valid) begin
        poison[rsp_slot] <= ue;
        pkind[rsp_slot]  <= rsp_kind;
      end
    end
  end

  AST_ONE_ERR_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_inst, err_data})); // R13
  AST_ERR_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (err_inst || err_data) |-> $past(ex_valid)); // R7
  AST_FILL_CACHEABLE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> $past(rsp_valid && rsp_cacheable)); // R5
  AST_UE_MARKED_L2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cacheable && rsp_err != 2'd0) |=> (fill_valid && l2_fill_mark)); // R2
  AST_ONE_L1_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> $onehot({l1i_fill_en, l1d_fill_en})); // R1
  AST_DMARK_NEEDS_DFILL: assert property (@(posedge clk) disable iff (!rst_n)
    l1d_fill_mark |-> (l1d_fill_en && l2_fill_mark)); // R4
endmodule

// File: tb/ue_fill_router_tb.sv
module ue_fill_router_tb;
  localparam int DW = 64;
  localparam int SLOTS = 8;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rsp_valid = 1'b0, rsp_cacheable = 1'b0, ex_valid = 1'b0;
  logic [SW-1:0] rsp_slot = '0, ex_slot = '0;
  logic [DW-1:0] rsp_data = '0;
  logic [1:0] rsp_err = '0, rsp_kind = '0;
  logic fill_valid, l2_fill_mark, l1i_fill_en, l1i_fill_par, l1d_fill_en, l1d_fill_mark;
  logic err_inst, err_data;
  logic [DW-1:0] fill_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit m_poison [SLOTS];
  logic [1:0] m_kind [SLOTS];

  always #5 clk = ~clk;

  ue_fill_router #(.DW(DW), .SLOTS(SLOTS)) u_dut (.*);

  task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_par(logic [DW-1:0] d, logic poisoned);
    return (^d) ^ poisoned;
  endfunction

  task automatic send(logic [SW-1:0] s, logic [1:0] e, logic c, logic [1:0] k, logic [DW-1:0] d);
    logic u;
    u = (e != 2'd0);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_slot = s; rsp_err = e; rsp_cacheable = c; rsp_kind = k; rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0;
    check("R6", "err_inst on arrival", err_inst, 0);
    check("R6", "err_data on arrival", err_data, 0);
    if (!c) begin
      check("R5", "fill_valid", fill_valid, 0);
      check("R5", "l1i_fill_en", l1i_fill_en, 0);
      check("R5", "l1d_fill_en", l1d_fill_en, 0);
    end else begin
      check("R1", "fill_valid", fill_valid, 1);
      check("R1", "fill_data", fill_data, d);
      check(u ? "R2" : "R1", "l2_fill_mark", l2_fill_mark, u);
      if (k == 2'd0) begin
        check("R3", "l1i_fill_en", l1i_fill_en, 1);
        check("R3", "l1d_fill_en", l1d_fill_en, 0);
        check(u ? "R3" : "R1", "l1i_fill_par", l1i_fill_par, exp_par(d, u));
      end else begin
        check("R4", "l1d_fill_en", l1d_fill_en, 1);
        check("R4", "l1i_fill_en", l1i_fill_en, 0);
        check(u ? "R4" : "R1", "l1d_fill_mark", l1d_fill_mark, u);
      end
    end
    m_poison[s] = u;
    m_kind[s] = k;
  endtask

  task automatic exec(logic [SW-1:0] s, string req);
    logic ei, ed;
    ei = m_poison[s] && m_kind[s] == 2'd0;
    ed = m_poison[s] && (m_kind[s] == 2'd1 || m_kind[s] == 2'd2);
    @(negedge clk);
    ex_valid = 1'b1; ex_slot = s;
    @(negedge clk);
    ex_valid = 1'b0;
    check(req, "err_inst", err_inst, ei);
    check(req, "err_data", err_data, ed);
    check("R13", "both errors", err_inst & err_data, 0);
    m_poison[s] = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < SLOTS; i++) begin m_poison[i] = 0; m_kind[i] = 2'd0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset fill_valid", fill_valid, 0);
    check("R13", "reset err_inst", err_inst, 0);
    check("R13", "reset err_data", err_data, 0);

    exec(3'd5, "R11");                                   // never-filled slot
    send(3'd0, 2'd0, 1'b1, 2'd0, 64'h0123_4567_89ab_cdef); // R1 clean fetch
    exec(3'd0, "R11");
    send(3'd1, 2'd1, 1'b1, 2'd0, 64'h0000_0000_0000_0001); // R2 R3 raw fetch
    exec(3'd1, "R9");
    exec(3'd1, "R12");
    send(3'd2, 2'd2, 1'b1, 2'd1, 64'hdead_beef_0000_ffff); // R4 marked load
    exec(3'd2, "R9");
    send(3'd3, 2'd1, 1'b0, 2'd0, 64'h5555_aaaa_5555_aaaa); // R5 nc fetch UE
    exec(3'd3, "R7");
    send(3'd4, 2'd2, 1'b0, 2'd1, 64'h1);                   // nc load UE
    exec(3'd4, "R8");
    exec(3'd4, "R12");
    send(3'd6, 2'd1, 1'b1, 2'd3, 64'hffff_ffff_ffff_ffff); // dw store UE
    exec(3'd6, "R10");
    send(3'd7, 2'd2, 1'b1, 2'd2, 64'h8000_0000_0000_0000); // store UE
    exec(3'd7, "R9");
    send(3'd7, 2'd0, 1'b1, 2'd2, 64'h42);                  // clean overwrite
    exec(3'd7, "R11");

    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(1, 0) == 0)
        send(SW'($urandom_range(SLOTS-1, 0)), 2'($urandom_range(3, 0)), 1'($urandom_range(1, 0)),
             2'($urandom_range(3, 0)), {$urandom, $urandom});
      else
        exec(SW'($urandom_range(SLOTS-1, 0)), "R12");
    end
    finish_run();
  end
endmodule